// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This block settles every control-flow instruction in one clock. For each accepted operation it reports whether control leaves the sequential path, the address of the next instruction and, for a call, the return address to be written into the link register. Conditional branches can compare two register operands directly, or compare one operand against zero. They can also test a set of condition flags that an earlier compare operation left behind. Relational tests can be signed or unsigned.

Branch and jump targets are the current PC plus a short signed word displacement. Returns and register-indirect jumps take their target from an operand, with the byte-offset bits cleared. The instruction size, operand width and displacement width are parameters. The condition-flag store can be removed by a parameter. When it is removed, flag branches are never taken.

Top module: `branch_resolve_unit`

## Requirements
- R1: After synchronous reset, `out_valid`, `taken`, `link_we`, `next_pc` and `link_data` are all zero. The stored flags read as "not equal, not less (signed and unsigned)", so a flag branch with relation GT is taken before any compare has run.
- R2: Results are registered. `out_valid` equals `in_valid` of the previous cycle. When `out_valid` is low, `taken` and `link_we` are low.
- R3: `rel` encodes the relation: 0 EQ, 1 NE, 2 GT, 3 LE, 4 LT, 5 GE. Codes 6 and 7 are never true. `cmp_signed`=1 makes GT/LE/LT/GE signed two's-complement comparisons, and 0 makes them unsigned.
- R4: With `cmp_zero`=1, the second compare operand is zero and `opb` has no effect on the outcome.
- R5: `kind` 1 is a fused compare-and-branch on `opa` against `opb` (or zero). When it is taken, `next_pc` = `pc` + sign-extended `disp` × 4. When it is not taken, `next_pc` = `pc` + 4.
- R6: `kind` 3 (jump) is always taken, with the same PC-relative target as R5.
- R7: `kind` 4 (call) is always taken to the PC-relative target. It raises `link_we` with `link_data` = `pc` + 4. No other kind raises `link_we`, and `link_data` is zero when `link_we` is low.
- R8: `kind` 5 (return, where `opa` carries the link register) and `kind` 6 (register-indirect jump) are always taken to `opa` with its two low bits cleared.
- R9: `kind` 7 (flag-setting compare) stores equal, signed-less and unsigned-less for `opa` against `opb` (or zero). It is not taken, and `next_pc` = `pc` + 4. The flags hold through all other kinds and through idle cycles until the next `kind` 7.
- R10: `kind` 2 (flag branch) evaluates `rel` and `cmp_signed` against the stored flags. Its taken and not-taken addresses follow R5. `kind` 0 is not taken and gives `pc` + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| kind | input | 3 | Control-flow kind (R5–R10) |
| rel | input | 3 | Compare relation code (R3) |
| cmp_signed | input | 1 | Signed relational compare |
| cmp_zero | input | 1 | Compare `opa` against zero |
| opa | input | XLEN | First operand / indirect or return target |
| opb | input | XLEN | Second operand |
| pc | input | XLEN | Address of the current instruction |
| disp | input | DISP_W | Signed word displacement |
| out_valid | output | 1 | Result present |
| taken | output | 1 | Control leaves sequential path |
| next_pc | output | XLEN | Address of next instruction |
| link_we | output | 1 | Write link register |
| link_data | output | XLEN | Return address for a call |

## Verification
The hardest case to reach from the ports is a flag branch that must read flags set several operations earlier. Unrelated jumps, calls and idle cycles have to pass in between without disturbing those flags. The stimulus therefore runs a flag-setting compare, then a run of other kinds and a gap with `in_valid` low, and only then a series of flag branches that probe every relation. A further compare with operands of mixed sign makes the signed and unsigned results disagree. The reset value of the flags is probed with a flag branch issued before any compare.

// File: rtl/bru_pkg.sv
package bru_pkg;

   typedef enum logic [2:0] {
      K_NONE  = 3'd0,
      K_BCMP  = 3'd1,
      K_BFLAG = 3'd2,
      K_JUMP  = 3'd3,
      K_CALL  = 3'd4,
      K_RET   = 3'd5,
      K_JIND  = 3'd6,
      K_SETF  = 3'd7
   } bkind_e;

   typedef enum logic [2:0] {
      REL_EQ = 3'd0,
      REL_NE = 3'd1,
      REL_GT = 3'd2,
      REL_LE = 3'd3,
      REL_LT = 3'd4,
      REL_GE = 3'd5
   } rel_e;

   typedef struct packed {
      logic eq;
      logic lt_s;
      logic lt_u;
   } cflags_t;

   // Turn a flag triple into a relation outcome.
   function automatic logic rel_true(input logic [2:0] r, input logic sgn,
                                     input cflags_t f);
      logic lt;
      lt = sgn ? f.lt_s : f.lt_u;
      case (r)
         REL_EQ:  rel_true = f.eq;
         REL_NE:  rel_true = !f.eq;
         REL_GT:  rel_true = !lt && !f.eq;
         REL_LE:  rel_true = lt || f.eq;
         REL_LT:  rel_true = lt;
         REL_GE:  rel_true = !lt;
         default: rel_true = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/bru_compare.sv
module bru_compare
   import bru_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            vs_zero,
   output cflags_t         flags
);
   logic [XLEN-1:0] rhs;

   assign rhs        = vs_zero ? '0 : b;
   assign flags.eq   = (a == rhs);
   assign flags.lt_u = (a < rhs);
   assign flags.lt_s = ($signed(a) < $signed(rhs));

endmodule

// File: rtl/bru_flags.sv
module bru_flags
   import bru_pkg::*;
#(
   parameter bit HAS_FLAGS = 1'b1
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    set,
   input  cflags_t d,
   output cflags_t q,
   output logic    usable
);
   generate
      if (HAS_FLAGS) begin : g_store
         cflags_t held;
         always_ff @(posedge clk) begin
            if (rst)      held <= '0;
            else if (set) held <= d;
         end
         assign q      = held;
         assign usable = 1'b1;
      end else begin : g_none
         logic unused_in;
         assign unused_in = clk ^ rst ^ set ^ (^d);
         assign q         = '0;
         assign usable    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bru_target.sv
module bru_target #(
   parameter int XLEN       = 32,
   parameter int DISP_W     = 10,
   parameter int INSN_BYTES = 4
) (
   input  logic [XLEN-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   input  logic [XLEN-1:0]   base,
   output logic [XLEN-1:0]   rel_tgt,
   output logic [XLEN-1:0]   seq_pc,
   output logic [XLEN-1:0]   ind_tgt
);
   localparam int SH = $clog2(INSN_BYTES);

   logic [XLEN-1:0] disp_ext;

   assign disp_ext = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
   assign rel_tgt  = pc + (disp_ext << SH);
   assign seq_pc   = pc + XLEN'(INSN_BYTES);
   assign ind_tgt  = {base[XLEN-1:SH], {SH{1'b0}}};

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
   import bru_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int DISP_W     = 10,
   parameter int INSN_BYTES = 4,
   parameter bit HAS_FLAGS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [2:0]        kind,
   input  logic [2:0]        rel,
   input  logic              cmp_signed,
   input  logic              cmp_zero,
   input  logic [XLEN-1:0]   opa,
   input  logic [XLEN-1:0]   opb,
   input  logic [XLEN-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   output logic              out_valid,
   output logic              taken,
   output logic [XLEN-1:0]   next_pc,
   output logic              link_we,
   output logic [XLEN-1:0]   link_data
);
   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("XLEN must be at least 8");
      end
      if (DISP_W < 2 || DISP_W >= XLEN) begin : g_bad_disp
         $error("DISP_W must lie in 2..XLEN-1");
      end
      if (INSN_BYTES < 2 || (INSN_BYTES & (INSN_BYTES - 1)) != 0) begin : g_bad_insn
         $error("INSN_BYTES must be a power of two, at least 2");
      end
   endgenerate

   cflags_t         live_f, held_f;
   logic            flags_ok;
   logic [XLEN-1:0] rel_tgt, seq_pc, ind_tgt;
   logic            set_f;
   logic            tk_c, lw_c;
   logic [XLEN-1:0] npc_c;
   bkind_e          k;

   assign k     = bkind_e'(kind);
   assign set_f = in_valid && (k == K_SETF);

   bru_compare #(.XLEN(XLEN)) u_cmp (
      .a       (opa),
      .b       (opb),
      .vs_zero (cmp_zero),
      .flags   (live_f)
   );

   bru_flags #(.HAS_FLAGS(HAS_FLAGS)) u_flags (
      .clk    (clk),
      .rst    (rst),
      .set    (set_f),
      .d      (live_f),
      .q      (held_f),
      .usable (flags_ok)
   );

   bru_target #(.XLEN(XLEN), .DISP_W(DISP_W), .INSN_BYTES(INSN_BYTES)) u_tgt (
      .pc      (pc),
      .disp    (disp),
      .base    (opa),
      .rel_tgt (rel_tgt),
      .seq_pc  (seq_pc),
      .ind_tgt (ind_tgt)
   );

   always_comb begin
      tk_c = 1'b0;
      lw_c = 1'b0;
      case (k)
         K_BCMP:  tk_c = rel_true(rel, cmp_signed, live_f);
         K_BFLAG: tk_c = flags_ok && rel_true(rel, cmp_signed, held_f);
         K_JUMP:  tk_c = 1'b1;
         K_CALL:  begin tk_c = 1'b1; lw_c = 1'b1; end
         K_RET:   tk_c = 1'b1;
         K_JIND:  tk_c = 1'b1;
         default: tk_c = 1'b0;
      endcase
      if (!tk_c)                           npc_c = seq_pc;
      else if (k == K_RET || k == K_JIND)  npc_c = ind_tgt;
      else                                 npc_c = rel_tgt;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         taken     <= 1'b0;
         next_pc   <= '0;
         link_we   <= 1'b0;
         link_data <= '0;
      end else begin
         out_valid <= in_valid;
         taken     <= in_valid && tk_c;
         next_pc   <= in_valid ? npc_c : '0;
         link_we   <= in_valid && lw_c;
         link_data <= (in_valid && lw_c) ? seq_pc : '0;
      end
   end

endmodule

// File: rtl/bru_chk.sv
module bru_chk #(
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 4
) (
   input logic            clk,
   input logic            rst,
   input logic            in_valid,
   input logic [2:0]      kind,
   input logic [XLEN-1:0] pc,
   input logic            out_valid,
   input logic            taken,
   input logic [XLEN-1:0] next_pc,
   input logic            link_we,
   input logic [XLEN-1:0] link_data
);
   localparam int SH = $clog2(INSN_BYTES);

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid == $past(in_valid));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (!taken && !link_we));

   // R5
   seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid ##1 (out_valid && !taken) |-> next_pc == $past(pc) + XLEN'(INSN_BYTES));

   // R6
   uncond_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && kind >= 3'd3 && kind <= 3'd6) |=> taken);

   // R7
   link_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid ##1 link_we |-> (taken && link_data == $past(pc) + XLEN'(INSN_BYTES)));

   // R8
   ind_align_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (kind == 3'd5 || kind == 3'd6)) |=> next_pc[SH-1:0] == '0);

   // R9
   setf_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && kind == 3'd7) |=> (!taken && !link_we));

endmodule

bind branch_resolve_unit bru_chk #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .kind      (kind),
   .pc        (pc),
   .out_valid (out_valid),
   .taken     (taken),
   .next_pc   (next_pc),
   .link_we   (link_we),
   .link_data (link_data)
);

// File: tb/branch_resolve_unit_tb.sv
`timescale 1ns/1ps
module branch_resolve_unit_tb;
   localparam int XLEN = 32;
   localparam int DW   = 10;

   typedef struct {
      logic            tk;
      logic [XLEN-1:0] npc;
      logic            lw;
      logic [XLEN-1:0] ld;
      string           tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [2:0] kind = '0, rel = '0;
   logic cmp_signed = 1'b0, cmp_zero = 1'b0;
   logic [XLEN-1:0] opa = '0, opb = '0, pc = '0;
   logic [DW-1:0] disp = '0;
   logic out_valid, taken, link_we;
   logic [XLEN-1:0] next_pc, link_data;

   int n_chk = 0, n_fail = 0;
   exp_t sb[$];
   logic m_eq = 1'b0, m_lts = 1'b0, m_ltu = 1'b0;

   always #2 clk = ~clk;

   branch_resolve_unit u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind), .rel(rel),
      .cmp_signed(cmp_signed), .cmp_zero(cmp_zero), .opa(opa), .opb(opb),
      .pc(pc), .disp(disp), .out_valid(out_valid), .taken(taken),
      .next_pc(next_pc), .link_we(link_we), .link_data(link_data)
   );

   function automatic logic eval(input logic [2:0] r, input logic s,
                                 input logic e, input logic ls, input logic lu);
      logic less;
      less = s ? ls : lu;
      case (r)
         3'd0: return e;
         3'd1: return !e;
         3'd2: return !(less || e);
         3'd3: return less || e;
         3'd4: return less;
         3'd5: return !less;
         default: return 1'b0;
      endcase
   endfunction

   task automatic op(input string tag, input logic [2:0] k, input logic [2:0] r,
                     input logic s, input logic z, input logic [XLEN-1:0] a,
                     input logic [XLEN-1:0] b, input logic [XLEN-1:0] p,
                     input logic signed [DW-1:0] d);
      exp_t e;
      logic [XLEN-1:0] rb, reltgt;
      logic ce, cls, clu;
      rb  = z ? '0 : b;
      ce  = (a == rb);
      cls = ($signed(a) < $signed(rb));
      clu = (a < rb);
      reltgt = p + XLEN'(signed'(d)) * 4;
      e.tag = tag; e.lw = 0; e.ld = '0; e.tk = 0;
      case (k)
         3'd1: e.tk = eval(r, s, ce, cls, clu);
         3'd2: e.tk = eval(r, s, m_eq, m_lts, m_ltu);
         3'd3, 3'd4, 3'd5, 3'd6: e.tk = 1;
         default: e.tk = 0;
      endcase
      if (k == 3'd4) begin e.lw = 1; e.ld = p + 4; end
      if (!e.tk) e.npc = p + 4;
      else if (k == 3'd5 || k == 3'd6) e.npc = a & ~32'h3;
      else e.npc = reltgt;
      if (k == 3'd7) begin m_eq = ce; m_lts = cls; m_ltu = clu; end
      @(negedge clk);
      in_valid = 1; kind = k; rel = r; cmp_signed = s; cmp_zero = z;
      opa = a; opb = b; pc = p; disp = d;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 0;
         opa = 32'hDEAD_BEEF; pc = 32'h1234_5678;
      end
   endtask

   always @(negedge clk) begin
      if (!rst && out_valid) begin
         n_chk++;
         if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL R2 unexpected result taken=%0b next_pc=%h expected none", taken, next_pc);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (taken !== e.tk || next_pc !== e.npc || link_we !== e.lw || link_data !== e.ld) begin
               n_fail++;
               $display("FAIL %s got tk=%0b npc=%h lw=%0b ld=%h exp tk=%0b npc=%h lw=%0b ld=%h",
                        e.tag, taken, next_pc, link_we, link_data, e.tk, e.npc, e.lw, e.ld);
            end
         end
      end else if (!rst && (taken || link_we)) begin
         n_chk++; n_fail++;
         $display("FAIL R2 idle output tk=%0b lw=%0b exp 0 0", taken, link_we);
      end
   end

   initial begin
      #(4 * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (out_valid !== 0 || taken !== 0 || link_we !== 0 || next_pc !== 0 || link_data !== 0) begin
         n_fail++;
         $display("FAIL R1 reset state got v=%0b tk=%0b lw=%0b npc=%h ld=%h exp all 0",
                  out_valid, taken, link_we, next_pc, link_data);
      end
      rst = 0;
      // R1: flags cleared -> GT taken, EQ not taken
      op("R1 flag GT after reset", 3'd2, 3'd2, 1, 0, 0, 0, 32'h100, 10'sd4);
      op("R1 flag EQ after reset", 3'd2, 3'd0, 1, 0, 0, 0, 32'h104, 10'sd4);
      // R3 / R5 fused compares
      op("R5 EQ taken", 3'd1, 3'd0, 0, 0, 32'd7, 32'd7, 32'h2000, 10'sd16);
      op("R5 NE not taken", 3'd1, 3'd1, 0, 0, 32'd7, 32'd7, 32'h2004, 10'sd16);
      op("R3 LT signed", 3'd1, 3'd4, 1, 0, 32'hFFFF_FFFF, 32'd1, 32'h3000, 10'sd8);
      op("R3 LT unsigned", 3'd1, 3'd4, 0, 0, 32'hFFFF_FFFF, 32'd1, 32'h3004, 10'sd8);
      op("R3 GE unsigned min disp", 3'd1, 3'd5, 0, 0, 32'hFFFF_FFFF, 32'd1, 32'h4000, -10'sd512);
      op("R3 GT signed max disp", 3'd1, 3'd2, 1, 0, 32'd5, 32'hFFFF_FFFB, 32'h4004, 10'sd511);
      op("R3 LE equal", 3'd1, 3'd3, 1, 0, 32'd9, 32'd9, 32'h4008, -10'sd1);
      op("R3 rel code 6", 3'd1, 3'd6, 0, 0, 32'd1, 32'd1, 32'h400C, 10'sd2);
      // R4 zero compare, opb ignored
      op("R4 zero LE", 3'd1, 3'd3, 1, 1, 32'd0, 32'd5, 32'h5000, 10'sd3);
      op("R4 zero GT", 3'd1, 3'd2, 1, 1, 32'd5, 32'd100, 32'h5004, 10'sd3);
      op("R4 zero EQ", 3'd1, 3'd0, 0, 1, 32'd0, 32'hFFFF, 32'h5008, -10'sd3);
      // R6 R7 R8
      op("R6 jump", 3'd3, 3'd7, 0, 0, 0, 0, 32'h6000, -10'sd100);
      op("R7 call", 3'd4, 3'd0, 0, 0, 1, 2, 32'h6100, 10'sd64);
      op("R8 return", 3'd5, 3'd0, 0, 0, 32'h0000_1003, 0, 32'h6200, 10'sd1);
      op("R8 indirect", 3'd6, 3'd1, 0, 0, 32'h8000_00FE, 0, 32'h6300, 10'sd1);
      op("R10 none kind", 3'd0, 3'd0, 0, 0, 0, 0, 32'h6400, 10'sd9);
      // R9 R10 flags
      op("R9 setf 3 vs 7", 3'd7, 3'd0, 0, 0, 32'd3, 32'd7, 32'h7000, 10'sd5);
      op("R9 hold jump", 3'd3, 3'd0, 0, 0, 0, 0, 32'h7004, 10'sd2);
      op("R9 hold call", 3'd4, 3'd0, 0, 0, 0, 0, 32'h7008, 10'sd2);
      idle(3);
      op("R10 flag LT", 3'd2, 3'd4, 1, 0, 0, 0, 32'h7100, 10'sd6);
      op("R10 flag GE", 3'd2, 3'd5, 1, 0, 0, 0, 32'h7104, 10'sd6);
      op("R10 flag NE", 3'd2, 3'd1, 0, 0, 0, 0, 32'h7108, -10'sd6);
      op("R9 setf mixed sign", 3'd7, 3'd0, 0, 0, 32'hFFFF_FFFE, 32'd3, 32'h7200, 10'sd0);
      op("R10 flag LT unsigned", 3'd2, 3'd4, 0, 0, 0, 0, 32'h7204, 10'sd7);
      op("R10 flag LT signed", 3'd2, 3'd4, 1, 0, 0, 0, 32'h7208, 10'sd7);
      op("R9 setf zero", 3'd7, 3'd0, 0, 1, 32'd0, 32'd44, 32'h7300, 10'sd0);
      op("R10 flag EQ", 3'd2, 3'd0, 0, 0, 0, 0, 32'h7304, 10'sd12);
      op("R10 flag LE", 3'd2, 3'd3, 1, 0, 0, 0, 32'h7308, 10'sd12);
      idle(4);
      n_chk++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R2 missing results got %0d pending exp 0", sb.size());
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule